// File: doc/BRIEF.md
# Address Window Decoder with Reserved-Hole Clipping

This block turns raw decode register values into two CPU-side address windows and then classifies any presented address against them. The first window is a general I/O window set by a low and a high register, both counted in 2 MiB granules. The second is a fixed 4 KiB window for the internal register file. Its base comes from one decode register and is moved upward when it would land inside either of two fixed reserved address holes.

A one-cycle update strobe captures the three register inputs. On the following clock edge the block latches the new bounds. An I/O update with inverted bounds is rejected, and the last good I/O window is kept. The internal window accepts every update. For each address, the block reports which window it falls in and the byte offset from that window's base. The internal window wins where the two windows overlap.

The control sequencer has two states. `ST_IDLE` waits for the strobe. `ST_APPLY` latches the bounds computed from the captured values. The transitions are: `ST_IDLE` to `ST_APPLY` when the strobe is seen; `ST_APPLY` to `ST_APPLY` when another strobe arrives (a fresh capture); and `ST_APPLY` to `ST_IDLE` otherwise.

Top module: `win_decode`

## Requirements
- R1: After reset both windows are off, `io_on` and `isd_on` are 0, both hit flags are 0 and `win_off` is 0.
- R2: When `upd_stb` is high at a rising edge, the register inputs are captured at that edge. The new bounds appear after the next rising edge. Changes to the register inputs while `upd_stb` is low have no effect on any bound.
- R3: An I/O update is accepted only when `io_lo_reg[6:0] <= io_hi_reg`. A rejected update leaves `io_base`, `io_size` and `io_on` unchanged. `io_on` becomes 1 at the first accepted update and stays 1.
- R4: For an accepted update, `io_base` = `io_lo_reg` (all 15 bits) << 21 and `io_size` = (`io_hi_reg` + 1 − `io_lo_reg[6:0]`) << 21.
- R5: Every update sets `isd_on` to 1. It also sets `isd_base` to `isd_reg` << 21 after two ordered clip steps. First, a base within [0x1E000000, 0x1F100000) becomes 0x1F100000. Then, a base within [0x1FC00000, 0x1FD00000) becomes 0x1FD00000.
- R6: A window hits when it is on and base <= `addr` < base + span. The span is `io_size` for the I/O window and 0x1000 for the internal window.
- R7: Where both windows would hit, only `isd_hit` is 1 and `io_hit` is 0. The two hit flags are never 1 together.
- R8: `win_off` is `addr` minus the base of the window that hits. It is 0 when neither window hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_stb | input | 1 | Capture strobe for the three register inputs |
| io_lo_reg | input | 15 | I/O window low bound, in 2 MiB granules |
| io_hi_reg | input | 7 | I/O window high bound, in 2 MiB granules (inclusive) |
| isd_reg | input | 15 | Internal register window base, in 2 MiB granules |
| addr | input | 36 | Address to classify |
| io_base | output | 36 | Latched I/O window base |
| io_size | output | 29 | Latched I/O window length in bytes |
| io_on | output | 1 | I/O window has been set at least once |
| isd_base | output | 36 | Latched, clipped internal window base |
| isd_on | output | 1 | Internal window has been set at least once |
| io_hit | output | 1 | Address falls in the I/O window and not in the internal one |
| isd_hit | output | 1 | Address falls in the internal window |
| win_off | output | 36 | Offset of the address within the window that hits |

## Verification
The bench builds the block with its default widths: 15-bit low and base registers, a 7-bit high register and a 21-bit granule shift. At these widths the internal base sweeps across the first 1024 granule codes, which includes every code that lands inside or next to either reserved hole. The I/O bounds sweep over a grid of low and high codes that covers both the equal-bounds case and the inverted-bounds case. This grid is combined with non-zero upper bits in the low register. Probe addresses are placed one byte inside and one byte outside each edge of a window. Overlapping windows exercise the priority rule.

// File: rtl/win_pkg.sv
package win_pkg;

    // Sequencer states for bound capture and application.
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } win_state_e;

endpackage

// File: rtl/win_clip.sv
// Moves a window base out of reserved holes. The holes are tested in a fixed order,
// so a base pushed to the top of one hole is then tested against the next hole.
module win_clip #(
    parameter int AW = 36,
    parameter logic [AW-1:0] H0_LO = 36'h0_1E00_0000,
    parameter logic [AW-1:0] H0_HI = 36'h0_1F10_0000,
    parameter logic [AW-1:0] H1_LO = 36'h0_1FC0_0000,
    parameter logic [AW-1:0] H1_HI = 36'h0_1FD0_0000
) (
    input  logic [AW-1:0] raw_base,
    output logic [AW-1:0] clip_base
);
    localparam int NHOLE = 2;
    localparam logic [NHOLE-1:0][AW-1:0] HLO = {H1_LO, H0_LO};
    localparam logic [NHOLE-1:0][AW-1:0] HHI = {H1_HI, H0_HI};

    logic [AW-1:0] stage [NHOLE+1];

    assign stage[0] = raw_base;

    for (genvar k = 0; k < NHOLE; k++) begin : g_hole
        always_comb begin
            if (stage[k] >= HLO[k] && stage[k] < HHI[k]) begin
                stage[k+1] = HHI[k];
            end else begin
                stage[k+1] = stage[k];
            end
        end
    end

    assign clip_base = stage[NHOLE];

endmodule

// File: rtl/win_io_calc.sv
// Derives the I/O window base and its length in granules, and whether the bounds are ordered.
module win_io_calc #(
    parameter int LO_W = 15,
    parameter int HI_W = 7,
    parameter int GSH  = 21
) (
    input  logic [LO_W-1:0]      lo_val,
    input  logic [HI_W-1:0]      hi_val,
    output logic                 bounds_ok,
    output logic [LO_W+GSH-1:0]  base,
    output logic [HI_W:0]        gran
);
    localparam int GW = HI_W + 1;

    logic [HI_W-1:0] lo_low;

    always_comb begin
        lo_low    = lo_val[HI_W-1:0];
        bounds_ok = (lo_low <= hi_val);
        base      = {lo_val, {GSH{1'b0}}};
        gran      = GW'({1'b0, hi_val}) + GW'(1) - GW'({1'b0, lo_low});
    end

endmodule

// File: rtl/win_match.sv
// Range match of one window: reports a hit and the offset from the window base.
module win_match #(
    parameter int AW = 36,
    parameter int SW = 29
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] span,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] off
);
    always_comb begin
        off = addr - base;
        hit = en && (addr >= base) && (off < AW'(span));
    end

endmodule

// File: rtl/win_decode.sv
module win_decode
    import win_pkg::*;
#(
    parameter int LO_W = 15,
    parameter int HI_W = 7,
    parameter int GSH  = 21,
    parameter int ISD_SPAN = 4096,
    parameter logic [31:0] HOLE0_LO = 32'h1E00_0000,
    parameter logic [31:0] HOLE0_HI = 32'h1F10_0000,
    parameter logic [31:0] HOLE1_LO = 32'h1FC0_0000,
    parameter logic [31:0] HOLE1_HI = 32'h1FD0_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_stb,
    input  logic [LO_W-1:0]       io_lo_reg,
    input  logic [HI_W-1:0]       io_hi_reg,
    input  logic [LO_W-1:0]       isd_reg,
    input  logic [LO_W+GSH-1:0]   addr,
    output logic [LO_W+GSH-1:0]   io_base,
    output logic [HI_W+GSH:0]     io_size,
    output logic                  io_on,
    output logic [LO_W+GSH-1:0]   isd_base,
    output logic                  isd_on,
    output logic                  io_hit,
    output logic                  isd_hit,
    output logic [LO_W+GSH-1:0]   win_off
);
    localparam int AW  = LO_W + GSH;
    localparam int GW  = HI_W + 1;
    localparam int SW  = GW + GSH;
    localparam int ISW = $clog2(ISD_SPAN) + 1;

    // Captured register values and sequencer state.
    win_state_e          state_q, state_d;
    logic [LO_W-1:0]     snap_lo_q;
    logic [HI_W-1:0]     snap_hi_q;
    logic [LO_W-1:0]     snap_isd_q;

    // Latched window bounds.
    logic [AW-1:0]       io_base_q;
    logic [GW-1:0]       io_gran_q;
    logic                io_on_q;
    logic [AW-1:0]       isd_base_q;
    logic                isd_on_q;

    // Computed bounds from the capture.
    logic                calc_ok;
    logic [AW-1:0]       calc_io_base;
    logic [GW-1:0]       calc_gran;
    logic [AW-1:0]       calc_isd_base;

    win_io_calc #(
        .LO_W (LO_W),
        .HI_W (HI_W),
        .GSH  (GSH)
    ) u_io_calc (
        .lo_val    (snap_lo_q),
        .hi_val    (snap_hi_q),
        .bounds_ok (calc_ok),
        .base      (calc_io_base),
        .gran      (calc_gran)
    );

    win_clip #(
        .AW    (AW),
        .H0_LO (AW'(HOLE0_LO)),
        .H0_HI (AW'(HOLE0_HI)),
        .H1_LO (AW'(HOLE1_LO)),
        .H1_HI (AW'(HOLE1_HI))
    ) u_clip (
        .raw_base  ({snap_isd_q, {GSH{1'b0}}}),
        .clip_base (calc_isd_base)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = upd_stb ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = upd_stb ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and capture registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_lo_q  <= '0;
            snap_hi_q  <= '0;
            snap_isd_q <= '0;
            io_base_q  <= '0;
            io_gran_q  <= '0;
            io_on_q    <= 1'b0;
            isd_base_q <= '0;
            isd_on_q   <= 1'b0;
        end else begin
            if (upd_stb) begin
                snap_lo_q  <= io_lo_reg;
                snap_hi_q  <= io_hi_reg;
                snap_isd_q <= isd_reg;
            end
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_APPLY: begin
                    isd_base_q <= calc_isd_base;
                    isd_on_q   <= 1'b1;
                    if (calc_ok) begin
                        io_base_q <= calc_io_base;
                        io_gran_q <= calc_gran;
                        io_on_q   <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Address classification.
    logic          io_raw_hit;
    logic [AW-1:0] io_off;
    logic [AW-1:0] isd_off;

    win_match #(
        .AW (AW),
        .SW (SW)
    ) u_io_match (
        .en   (io_on_q),
        .base (io_base_q),
        .span ({io_gran_q, {GSH{1'b0}}}),
        .addr (addr),
        .hit  (io_raw_hit),
        .off  (io_off)
    );

    win_match #(
        .AW (AW),
        .SW (ISW)
    ) u_isd_match (
        .en   (isd_on_q),
        .base (isd_base_q),
        .span (ISW'(ISD_SPAN)),
        .addr (addr),
        .hit  (isd_hit),
        .off  (isd_off)
    );

    always_comb begin
        io_hit = io_raw_hit && !isd_hit;
        if (isd_hit) begin
            win_off = isd_off;
        end else if (io_hit) begin
            win_off = io_off;
        end else begin
            win_off = '0;
        end
    end

    assign io_base  = io_base_q;
    assign io_size  = {io_gran_q, {GSH{1'b0}}};
    assign io_on    = io_on_q;
    assign isd_base = isd_base_q;
    assign isd_on   = isd_on_q;

endmodule

// File: rtl/win_chk.sv
module win_chk
    import win_pkg::*;
#(
    parameter int LO_W = 15,
    parameter int HI_W = 7,
    parameter int GSH  = 21,
    parameter int ISD_SPAN = 4096,
    parameter logic [31:0] HOLE0_LO = 32'h1E00_0000,
    parameter logic [31:0] HOLE0_HI = 32'h1F10_0000,
    parameter logic [31:0] HOLE1_LO = 32'h1FC0_0000,
    parameter logic [31:0] HOLE1_HI = 32'h1FD0_0000
) (
    input logic                 clk,
    input logic                 rst_n,
    input win_state_e           state_q,
    input logic [LO_W-1:0]      snap_lo_q,
    input logic [HI_W-1:0]      snap_hi_q,
    input logic [LO_W+GSH-1:0]  io_base,
    input logic [HI_W+GSH:0]    io_size,
    input logic                 io_on,
    input logic [LO_W+GSH-1:0]  isd_base,
    input logic                 isd_on,
    input logic                 io_hit,
    input logic                 isd_hit,
    input logic [LO_W+GSH-1:0]  win_off
);
    localparam int AW = LO_W + GSH;

    p_one_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hit && isd_hit));

    p_zero_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_hit || isd_hit) |-> (win_off == '0));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(io_base) && $stable(io_size) && $stable(isd_base)));

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && snap_lo_q[HI_W-1:0] > snap_hi_q)
            |=> ($stable(io_base) && $stable(io_size) && $stable(io_on)));

    p_io_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_on |=> io_on);

    p_isd_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        isd_hit |-> (win_off < AW'(ISD_SPAN)));

    p_no_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        isd_on |-> !((isd_base >= AW'(HOLE0_LO) && isd_base < AW'(HOLE0_HI)) ||
                     (isd_base >= AW'(HOLE1_LO) && isd_base < AW'(HOLE1_HI))));

    p_off_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !isd_on |-> !isd_hit);

endmodule

bind win_decode win_chk #(
    .LO_W     (LO_W),
    .HI_W     (HI_W),
    .GSH      (GSH),
    .ISD_SPAN (ISD_SPAN),
    .HOLE0_LO (HOLE0_LO),
    .HOLE0_HI (HOLE0_HI),
    .HOLE1_LO (HOLE1_LO),
    .HOLE1_HI (HOLE1_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .snap_lo_q (snap_lo_q),
    .snap_hi_q (snap_hi_q),
    .io_base   (io_base),
    .io_size   (io_size),
    .io_on     (io_on),
    .isd_base  (isd_base),
    .isd_on    (isd_on),
    .io_hit    (io_hit),
    .isd_hit   (isd_hit),
    .win_off   (win_off)
);

// File: tb/sim_win_decode.sv
`timescale 1ns/1ps
module sim_win_decode;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd_stb = 1'b0;
    logic [14:0]  io_lo_reg = '0;
    logic [6:0]   io_hi_reg = '0;
    logic [14:0]  isd_reg = '0;
    logic [35:0]  addr = '0;
    logic [35:0]  io_base;
    logic [28:0]  io_size;
    logic         io_on;
    logic [35:0]  isd_base;
    logic         isd_on;
    logic         io_hit;
    logic         isd_hit;
    logic [35:0]  win_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    bit           m_io_on = 0;
    logic [35:0]  m_io_base = '0;
    logic [35:0]  m_io_size = '0;
    bit           m_isd_on = 0;
    logic [35:0]  m_isd_base = '0;

    always #5 clk = ~clk;

    win_decode u0 (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb),
        .io_lo_reg(io_lo_reg), .io_hi_reg(io_hi_reg), .isd_reg(isd_reg),
        .addr(addr), .io_base(io_base), .io_size(io_size), .io_on(io_on),
        .isd_base(isd_base), .isd_on(isd_on), .io_hit(io_hit),
        .isd_hit(isd_hit), .win_off(win_off)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] clip_ref(input logic [14:0] g);
        logic [35:0] b;
        b = {g, 21'h0};
        if (b >= 36'h1E00_0000 && b < 36'h1F10_0000) b = 36'h1F10_0000;
        if (b >= 36'h1FC0_0000 && b < 36'h1FD0_0000) b = 36'h1FD0_0000;
        return b;
    endfunction

    // Present a strobe at a falling edge; bounds are visible two edges later.
    task automatic do_update(input logic [14:0] lo, input logic [6:0] hi, input logic [14:0] isd);
        @(negedge clk);
        io_lo_reg = lo; io_hi_reg = hi; isd_reg = isd; upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        @(negedge clk);
        m_isd_on = 1; m_isd_base = clip_ref(isd);
        if (lo[6:0] <= hi) begin
            m_io_on = 1;
            m_io_base = {lo, 21'h0};
            m_io_size = 36'({8'(hi) + 8'd1 - 8'(lo[6:0]), 21'h0});
        end
    endtask

    task automatic check_bounds(input string req);
        chk(io_on == m_io_on, req, "io_on", 64'(io_on), 64'(m_io_on));
        chk(isd_on == m_isd_on, req, "isd_on", 64'(isd_on), 64'(m_isd_on));
        if (m_io_on) begin
            chk(io_base == m_io_base, req, "io_base", 64'(io_base), 64'(m_io_base));
            chk(36'(io_size) == m_io_size, req, "io_size", 64'(io_size), 64'(m_io_size));
        end
        chk(isd_base == m_isd_base, req, "isd_base", 64'(isd_base), 64'(m_isd_base));
    endtask

    task automatic probe(input logic [35:0] a, input string req);
        bit e_isd, e_io;
        logic [35:0] e_off;
        addr = a;
        #2;
        e_isd = m_isd_on && a >= m_isd_base && (a - m_isd_base) < 36'h1000;
        e_io  = m_io_on && a >= m_io_base && (a - m_io_base) < m_io_size && !e_isd;
        e_off = e_isd ? a - m_isd_base : (e_io ? a - m_io_base : 36'h0);
        chk(isd_hit == e_isd, req, "isd_hit", 64'(isd_hit), 64'(e_isd));
        chk(io_hit == e_io, req, "io_hit", 64'(io_hit), 64'(e_io));
        chk(win_off == e_off, req, "win_off", 64'(win_off), 64'(e_off));
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk(!io_on && !isd_on, "R1", "windows off", 64'({io_on, isd_on}), 64'h0);
        probe(36'h0, "R1");
        probe(36'h1000, "R1");

        // R3: inverted first update leaves I/O off; R5: internal window on.
        do_update(15'd5, 7'd3, 15'h7FFF);
        check_bounds("R3");
        chk(isd_on == 1'b1, "R5", "isd_on first", 64'(isd_on), 64'h1);

        // R2: timing of the latch, and inputs ignored without a strobe.
        @(negedge clk);
        io_lo_reg = 15'h0102; io_hi_reg = 7'd9; isd_reg = 15'h0011; upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        chk(io_on == 1'b0, "R2", "no change after one edge", 64'(io_on), 64'h0);
        chk(isd_base == m_isd_base, "R2", "isd old after one edge", 64'(isd_base), 64'(m_isd_base));
        @(negedge clk);
        m_io_on = 1; m_io_base = {15'h0102, 21'h0}; m_io_size = 36'({8'd8, 21'h0});
        m_isd_base = clip_ref(15'h0011);
        check_bounds("R2");
        io_lo_reg = 15'h0300; io_hi_reg = 7'd127; isd_reg = 15'h00F4;
        repeat (4) @(negedge clk);
        check_bounds("R2");

        // R5, R6: sweep internal base over the low granule codes, I/O window parked.
        for (int v = 0; v < 1024; v++) begin
            do_update(15'h7F00, 7'd0, 15'(v));
            check_bounds("R5");
            probe(m_isd_base, "R6");
            probe(m_isd_base + 36'hFFF, "R6");
            probe(m_isd_base + 36'h1000, "R6");
        end

        // R3, R4, R6, R8: sweep I/O bounds with the internal window out of the way.
        for (int l = 0; l < 128; l += 7) begin
            for (int h = 0; h < 128; h += 13) begin
                logic [14:0] lo;
                lo = {8'((l * 37 + h) & 8'h3F), 7'(l)};
                do_update(lo, 7'(h), 15'h7FFF);
                check_bounds("R4");
                probe(m_io_base - 36'd1, "R6");
                probe(m_io_base, "R6");
                probe(m_io_base + m_io_size - 36'd1, "R8");
                probe(m_io_base + m_io_size, "R6");
            end
        end

        // R7: internal window inside the I/O window takes priority.
        do_update(15'd0, 7'd127, 15'h0010);
        check_bounds("R7");
        probe(36'h200_0010, "R7");
        probe(36'h200_0FFF, "R7");
        probe(36'h200_1000, "R8");
        probe(36'h1FF_FFFF, "R8");
        chk(isd_hit == 1'b0 && io_hit == 1'b1, "R7", "io wins outside isd",
            64'({isd_hit, io_hit}), 64'h1);

        // R5: hole edges explicitly.
        do_update(15'd0, 7'd0, 15'h00F8);
        chk(isd_base == 36'h1F10_0000, "R5", "hole0 top granule", 64'(isd_base), 64'h1F10_0000);
        do_update(15'd0, 7'd0, 15'h00FE);
        chk(isd_base == 36'h1FD0_0000, "R5", "hole1", 64'(isd_base), 64'h1FD0_0000);
        do_update(15'd0, 7'd0, 15'h00FF);
        chk(isd_base == 36'h1FE0_0000, "R5", "above hole1", 64'(isd_base), 64'h1FE0_0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule